// File: doc/BRIEF.md
# Dual-Strobe Decade Up/Down Counter

A single BCD digit counter that moves up or down depending on which of two strobe inputs receives a rising edge. One strobe counts up and the other counts down. Whichever strobe is not in use must rest high. An active-low load copies a 4-bit preset into the digit, and an active-high clear zeroes it. Clear wins over load, and load wins over counting. All sixteen codes have a defined successor. The six non-decimal codes fall back into the 0..9 range along a fixed escape path.

The strobes are asynchronous to the system clock. Each strobe passes through a synchronizer, and its rising edge is detected on the clock. A count is applied three clock edges after the strobe rises. Load and clear are sampled directly on the clock edge. Two active-low terminal outputs allow digits to be chained. The carry output pulses low while the up strobe is low on a digit that has bits 0 and 3 set. The borrow output pulses low while the down strobe is low on a digit of zero. A multi-digit counter is built by feeding carry into the next stage's up strobe and borrow into its down strobe. Reset is asserted asynchronously and released through a two-flop synchronizer.

Top module: `bcd_updown_ctr`

## Requirements
- R1: After reset, count_o is 0 and carry_n_o is 1. borrow_n_o is 0 whenever the synchronized down strobe is low, and 1 otherwise.
- R2: When clear_i is 1 at a clock edge, count_o becomes 0 at that edge, whatever load_n_i, preset_i and the strobes are doing.
- R3: When load_n_i is 0 and clear_i is 0 at a clock edge, count_o takes the value of preset_i at that edge. Strobe activity during load has no effect.
- R4: A rising edge on up_i while dn_i stays high adds one to the digit. The change appears at the third clock edge after the rise. The digit wraps from 9 to 0.
- R5: A rising edge on dn_i while up_i stays high subtracts one from the digit. The change appears at the third clock edge after the rise. The digit wraps from 0 to 9.
- R6: The digit does not change while both strobes rest high. It does not change when one strobe rises while the other is low. It does not change when both strobes rise in the same clock cycle.
- R7: Counting up from a non-decimal code follows this path: 10 goes to 11, 11 to 6, 12 to 13, 13 to 4, 14 to 15, and 15 to 2.
- R8: Counting down from 15 steps through 14, 13, 12, 11 and 10, and then reaches 9.
- R9: carry_n_o is 0 exactly when count_o is one of 9, 11, 13 or 15 and the synchronized up strobe is low.
- R10: borrow_n_o is 0 exactly when count_o is 0 and the synchronized down strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_i | input | 1 | Count-up strobe; counts on its rising edge |
| dn_i | input | 1 | Count-down strobe; counts on its rising edge |
| clear_i | input | 1 | Active-high clear |
| load_n_i | input | 1 | Active-low parallel load |
| preset_i | input | 4 | Value copied in on load |
| count_o | output | 4 | Current digit |
| carry_n_o | output | 1 | Active-low carry terminal output |
| borrow_n_o | output | 1 | Active-low borrow terminal output |

## Verification
The hardest cases to reach from the ports are the six non-decimal codes, because normal counting never enters them. The bench reaches each code with a parallel load and then sends a single up strobe from it, and it walks down from 15 to 9 the same way. The ordering cases also need deliberate stimulus: a strobe that rises while the other rests low, and both strobes rising in the same cycle. The bench lowers both strobes and then releases them in chosen orders. A behavioural model that tracks the synchronizer delay is compared against the outputs on every clock.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;
  localparam int unsigned DIGIT_W   = 4;
  localparam int unsigned DIGIT_MAX = 9;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_UP,
    ACT_DOWN,
    ACT_LOAD,
    ACT_CLEAR
  } ctr_act_e;
endpackage

// File: rtl/ctr_rst_sync.sv
module ctr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_q_n = sr_q[STAGES-1];
endmodule

// File: rtl/ctr_strobe_sync.sv
module ctr_strobe_sync #(
  parameter int unsigned CHANNELS = 2,
  parameter int unsigned STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] strobe_i,
  output logic [CHANNELS-1:0] level_o,
  output logic [CHANNELS-1:0] rise_o
);
  for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
    logic [STAGES:0] pipe_q;
    logic [STAGES:0] pipe_d;

    always_comb begin
      pipe_d = {pipe_q[STAGES-1:0], strobe_i[g]};
    end

    // idle level of a strobe is high, so reset to ones to avoid a false edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= pipe_d;
    end

    assign level_o[g] = pipe_q[STAGES-1];
    assign rise_o[g]  = pipe_q[STAGES-1] & ~pipe_q[STAGES];

    // one event per strobe edge
    p_rise_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/bcd_step.sv
module bcd_step
  import bcd_ctr_pkg::*;
(
  input  digit_t cur_i,
  output digit_t up_o,
  output digit_t dn_o
);
  always_comb begin
    unique case (cur_i)
      digit_t'(9):  up_o = digit_t'(0);
      digit_t'(11): up_o = digit_t'(6);
      digit_t'(13): up_o = digit_t'(4);
      digit_t'(15): up_o = digit_t'(2);
      default:      up_o = cur_i + digit_t'(1);
    endcase
    dn_o = (cur_i == '0) ? digit_t'(DIGIT_MAX) : cur_i - digit_t'(1);
  end

  always_comb begin
    if (cur_i <= digit_t'(DIGIT_MAX)) begin
      p_stay_decimal_r4: assert (up_o <= digit_t'(DIGIT_MAX) && dn_o <= digit_t'(DIGIT_MAX));
    end
    if (cur_i > digit_t'(DIGIT_MAX) && cur_i[0]) begin
      p_escape_lands_r7: assert (up_o < digit_t'(DIGIT_MAX));
    end
  end
endmodule

// File: rtl/bcd_updown_ctr.sv
module bcd_updown_ctr
  import bcd_ctr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_i,
  input  logic         dn_i,
  input  logic         clear_i,
  input  logic         load_n_i,
  input  logic [3:0]   preset_i,
  output logic [3:0]   count_o,
  output logic         carry_n_o,
  output logic         borrow_n_o
);
  localparam int unsigned CH_UP = 0;
  localparam int unsigned CH_DN = 1;

  logic       rst_q_n;
  logic [1:0] lvl;
  logic [1:0] rise;
  logic       up_lvl, dn_lvl, up_evt, dn_evt;
  digit_t     digit_q, digit_d, step_up, step_dn;
  ctr_act_e   act;
  logic       digit_en;

  ctr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  ctr_strobe_sync #(.CHANNELS(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q_n), .strobe_i({dn_i, up_i}),
    .level_o(lvl), .rise_o(rise)
  );

  bcd_step u_step (.cur_i(digit_q), .up_o(step_up), .dn_o(step_dn));

  assign up_lvl = lvl[CH_UP];
  assign dn_lvl = lvl[CH_DN];
  assign up_evt = rise[CH_UP] & ~rise[CH_DN] & dn_lvl;
  assign dn_evt = rise[CH_DN] & ~rise[CH_UP] & up_lvl;

  always_comb begin
    if (clear_i)        act = ACT_CLEAR;
    else if (!load_n_i) act = ACT_LOAD;
    else if (up_evt)    act = ACT_UP;
    else if (dn_evt)    act = ACT_DOWN;
    else                act = ACT_HOLD;
  end

  always_comb begin
    digit_en = (act != ACT_HOLD);
    unique case (act)
      ACT_CLEAR: digit_d = '0;
      ACT_LOAD:  digit_d = preset_i;
      ACT_UP:    digit_d = step_up;
      ACT_DOWN:  digit_d = step_dn;
      default:   digit_d = digit_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)      digit_q <= '0;
    else if (digit_en) digit_q <= digit_d;
  end

  assign count_o    = digit_q;
  assign carry_n_o  = ~(digit_q[0] & digit_q[3] & ~up_lvl);
  assign borrow_n_o = ~((digit_q == '0) & ~dn_lvl);

  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    clear_i |=> (count_o == 4'd0 && carry_n_o));
  p_load_copy_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!clear_i && !load_n_i) |=> count_o == $past(preset_i));
  p_wrap_up_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!clear_i && load_n_i && up_evt && count_o == 4'd9) |=> count_o == 4'd0);
  p_wrap_dn_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!clear_i && load_n_i && dn_evt && count_o == 4'd0) |=> count_o == 4'd9);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!clear_i && load_n_i && !up_evt && !dn_evt) |=> $stable(count_o));
  p_down_escape_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!clear_i && load_n_i && dn_evt && count_o > 4'd9) |=> count_o == $past(count_o) - 4'd1);
  p_carry_codes_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !carry_n_o |-> (!up_lvl && (count_o == 4'd9 || count_o == 4'd11 ||
                                count_o == 4'd13 || count_o == 4'd15)));
  p_borrow_zero_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !borrow_n_o |-> (count_o == 4'd0 && !dn_lvl));
endmodule

// File: tb/bcd_updown_ctr_bench.sv
module bcd_updown_ctr_bench;
  logic       clk = 1'b0;
  logic       rst_n, up_i, dn_i, clear_i, load_n_i;
  logic [3:0] preset_i;
  logic [3:0] count_o;
  logic       carry_n_o, borrow_n_o;

  int total = 0;
  int bad   = 0;
  bit chk_en = 1'b0;
  bit done   = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  int unsigned mq = 0;
  bit u1 = 1, u2 = 1, u3 = 1, d1 = 1, d2 = 1, d3 = 1;
  int rcnt = 0;

  always #4 clk = ~clk;

  bcd_updown_ctr u_bcd_updown_ctr (
    .clk(clk), .rst_n(rst_n), .up_i(up_i), .dn_i(dn_i), .clear_i(clear_i),
    .load_n_i(load_n_i), .preset_i(preset_i), .count_o(count_o),
    .carry_n_o(carry_n_o), .borrow_n_o(borrow_n_o)
  );

  function automatic int unsigned ref_up(int unsigned v);
    if (v == 9) return 0;
    if (v > 9 && (v % 2) == 1) return 17 - v;
    return v + 1;
  endfunction

  function automatic int unsigned ref_dn(int unsigned v);
    return (v == 0) ? 9 : v - 1;
  endfunction

  always @(posedge clk) begin
    bit live, ur, dr;
    live = (rcnt >= 2);
    if (!rst_n || !live) begin
      mq = 0;
      u1 = 1; u2 = 1; u3 = 1; d1 = 1; d2 = 1; d3 = 1;
    end else begin
      ur = u2 && !u3;
      dr = d2 && !d3;
      if (clear_i)                 mq = 0;
      else if (!load_n_i)          mq = preset_i;
      else if (ur && !dr && d2)    mq = ref_up(mq);
      else if (dr && !ur && u2)    mq = ref_dn(mq);
      u3 = u2; u2 = u1; u1 = up_i;
      d3 = d2; d2 = d1; d1 = dn_i;
    end
    if (!rst_n) rcnt = 0;
    else if (rcnt < 2) rcnt++;
  end

  task automatic check(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    bit ec, eb;
    if (chk_en && !done) begin
      ec = !((mq % 2) == 1 && mq >= 8 && !u2);
      eb = !(mq == 0 && !d2);
      check({cur_req, " count"}, count_o, mq);
      check("R9 carry", carry_n_o, ec);
      check("R10 borrow", borrow_n_o, eb);
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic probe(string req, int got, int exp);
    @(negedge clk);
    #1;
    check(req, got, exp);
  endtask

  task automatic pulse_up();
    up_i = 0; tick(3); up_i = 1; tick(4);
  endtask

  task automatic pulse_dn();
    dn_i = 0; tick(3); dn_i = 1; tick(4);
  endtask

  task automatic load_val(int v);
    preset_i = v[3:0]; load_n_i = 0; tick(1); load_n_i = 1; tick(1);
  endtask

  initial begin
    int esc_exp[6] = '{11, 6, 13, 4, 15, 2};
    rst_n = 0; up_i = 1; dn_i = 1; clear_i = 0; load_n_i = 1; preset_i = 0;
    tick(3);
    rst_n = 1;
    tick(1);
    chk_en = 1;
    tick(3);
    // R1 reset state
    cur_req = "R1";
    probe("R1 count", count_o, 0);
    probe("R1 carry", carry_n_o, 1);
    probe("R1 borrow idle", borrow_n_o, 1);
    dn_i = 0; tick(3);
    probe("R1 borrow active", borrow_n_o, 0);
    up_i = 0; tick(3); up_i = 1; tick(3);   // up rises while dn low: blocked
    probe("R6 idle low blocks", count_o, 0);
    dn_i = 1; tick(4);                      // dn rises with up high: down from 0
    probe("R5 wrap 0 to 9", count_o, 9);

    // R4 up counting and wrap
    cur_req = "R4";
    up_i = 0; tick(3);
    probe("R9 carry at 9", carry_n_o, 0);
    up_i = 1; tick(4);
    probe("R4 wrap 9 to 0", count_o, 0);
    probe("R9 carry released", carry_n_o, 1);
    for (int i = 0; i < 7; i++) pulse_up();
    probe("R4 up to 7", count_o, 7);

    // R5 down counting
    cur_req = "R5";
    for (int i = 0; i < 7; i++) pulse_dn();
    probe("R5 down to 0", count_o, 0);
    dn_i = 0; tick(3);
    probe("R10 borrow at 0", borrow_n_o, 0);
    dn_i = 1; tick(4);
    probe("R5 wrap 0 to 9", count_o, 9);

    // R6 simultaneous rise and idle
    cur_req = "R6";
    up_i = 0; dn_i = 0; tick(4);
    up_i = 1; dn_i = 1; tick(5);
    probe("R6 both rise", count_o, 9);
    tick(10);
    probe("R6 both high", count_o, 9);

    // R7 escape path upward
    cur_req = "R7";
    for (int v = 10; v < 16; v++) begin
      load_val(v);
      pulse_up();
      probe("R7 escape up", count_o, esc_exp[v-10]);
    end
    load_val(13); up_i = 0; tick(3);
    probe("R9 carry at 13", carry_n_o, 0);
    up_i = 1; tick(4);

    // R8 escape downward
    cur_req = "R8";
    load_val(15);
    for (int i = 0; i < 6; i++) pulse_dn();
    probe("R8 down to 9", count_o, 9);

    // R3 load overrides strobes
    cur_req = "R3";
    preset_i = 4'd3; load_n_i = 0;
    up_i = 0; tick(3); up_i = 1; tick(4);
    probe("R3 load wins", count_o, 3);
    load_n_i = 1; tick(2);

    // R2 clear overrides load
    cur_req = "R2";
    preset_i = 4'd7; load_n_i = 0; clear_i = 1;
    dn_i = 0; tick(3); dn_i = 1; tick(3);
    probe("R2 clear wins", count_o, 0);
    clear_i = 0; load_n_i = 1; tick(3);
    probe("R2 stays 0", count_o, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule